// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the software-visible control slice of a multi-channel DMA controller. Every channel has its own 256-byte window on a 32-bit memory-mapped bus. Each window holds the transfer setup words, a run bit, a busy flag, interrupt enables, and raw and masked interrupt flags. The block sends a one-cycle start or abort pulse to the transfer engine for a channel. It takes back one-cycle done, error and halted pulses from the engine.

Clearing the run bit only asks the engine to stop. The busy flag stays set until the engine reports that it has halted, so software can poll the status word to learn when the channel is quiet. The masked flags of every channel are ORed into one interrupt line. Software reads the masked flag word of each channel to find the source, then clears the raw flags by writing ones.

The bus interface has no wait states. A write takes effect on the clock edge where `bus_we` is high. Read data is combinational from the address. A channel is selected by `bus_addr[AW-1:8]`, and the word within its window by `bus_addr[7:2]`. An access whose address has low bits `[1:0]` not zero is not decoded.

Top module: `dmac_regfile`

## Requirements
- R1: After reset every readable word of every channel reads 0, no engine pulse is driven, and `irq_o` is 0.
- R2: While the channel is idle, the nine setup words at offsets 0x08, 0x10, 0x14, 0x18, 0x1C, 0x20, 0x24, 0x28 and 0x2C store all 32 written bits. They read back at the same offset and appear on `setup_o`: channel c, setup index k (in offset order), bits `[c*288 + k*32 +: 32]`.
- R3: Writing 1 to bit 0 of offset 0x30 on an idle channel sets the run bit (0x30 bit 0) and the busy bit (status word 0x40, bit 0). It also drives `eng_start_o` for that channel for exactly the one cycle after the write edge.
- R4: Writes to the setup words while the busy bit is set leave them unchanged.
- R5: Writing 0 to bit 0 of offset 0x30 while the channel is running clears the run bit and drives `eng_abort_o` for the one cycle after the write edge. The busy bit stays 1 until an `eng_halted_i` pulse arrives, and it is 0 after that pulse.
- R6: An `eng_done_i` or `eng_error_i` pulse clears both the run bit and the busy bit.
- R7: The raw flag word 0x44 holds the end flag in bit 0, set by `eng_done_i`, and the error flag in bit 1, set by `eng_error_i`. Writing 1 to a bit clears it and writing 0 has no effect. An event in the same cycle as a clearing write leaves the flag set.
- R8: The enable word 0x34 has bit 0 as the end enable and bit 1 as the error enable. The masked word 0x48 reads the raw flags ANDed with these enables.
- R9: `irq_o` is 1 exactly when some channel has a nonzero masked word. Each channel's words sit at channel index × 0x100 plus the offset.
- R10: Writing 1 to bit 0 of 0x30 while the channel is busy produces no `eng_start_o` pulse.
- R11: Writes to the status word 0x40 and the masked word 0x48 have no effect. Reads of undecoded offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | AW (10) | Byte address: channel index above bit 8, word offset below |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| eng_start_o | output | NUM_CH | One-cycle start request per channel |
| eng_abort_o | output | NUM_CH | One-cycle abort request per channel |
| eng_done_i | input | NUM_CH | Transfer finished pulse per channel |
| eng_error_i | input | NUM_CH | Transfer failed pulse per channel |
| eng_halted_i | input | NUM_CH | Engine stopped after abort, per channel |
| setup_o | output | NUM_CH*288 | Setup words of all channels |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a raw flag being set by the engine in the same cycle as a software write that clears it. A plain sequence of bus accesses never produces this. The stimulus raises the done pulse and the clearing write on the same falling edge, so both reach the flag logic at one clock edge. The drain window of an abort is also checked. The engine halted pulse is held back for several cycles, and status is polled in between to show that busy has not dropped early.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   localparam int DATA_W   = 32;
   localparam int WORD_W   = 6;
   localparam int SETUP_N  = 9;
   localparam int MAX_CH   = 16;
   localparam logic [WORD_W-1:0] W_CTL  = 6'd12;
   localparam logic [WORD_W-1:0] W_IEN  = 6'd13;
   localparam logic [WORD_W-1:0] W_STAT = 6'd16;
   localparam logic [WORD_W-1:0] W_RAW  = 6'd17;
   localparam logic [WORD_W-1:0] W_MSK  = 6'd18;

   // word index of setup slot k: slot 0 is at 0x08, slots 1..8 follow from 0x10
   function automatic logic [WORD_W-1:0] setup_word(input int k);
      return (k == 0) ? 6'd2 : 6'(k + 3);
   endfunction
endpackage

// File: rtl/dmac_irq_merge.sv
module dmac_irq_merge #(
   parameter int N   = 4,
   parameter int REG = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq_in,
   output logic         irq_out
);
   if (REG != 0) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) irq_out <= 1'b0;
         else        irq_out <= |irq_in;
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq_out = |irq_in;
   end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
   import dmac_pkg::*;
(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [WORD_W-1:0]         word,
   input  logic [DATA_W-1:0]         wdata,
   output logic [DATA_W-1:0]         rdata,
   input  logic                      eng_done,
   input  logic                      eng_error,
   input  logic                      eng_halted,
   output logic                      eng_start,
   output logic                      eng_abort,
   output logic [SETUP_N*DATA_W-1:0] setup,
   output logic                      irq
);
   logic [DATA_W-1:0] setup_q [SETUP_N];
   logic       run_q, busy_q;
   logic [1:0] raw_q, ien_q, masked;
   logic       wr_ctl, go, stop, end_ev;

   assign wr_ctl = wr_en && (word == W_CTL);
   assign go     = wr_ctl && wdata[0] && !busy_q;
   assign stop   = wr_ctl && !wdata[0] && busy_q && run_q;
   assign end_ev = eng_done || eng_error;

   for (genvar k = 0; k < SETUP_N; k++) begin : g_setup
      always_ff @(posedge clk) begin
         if (!rst_n)
            setup_q[k] <= '0;
         else if (wr_en && !busy_q && word == setup_word(k))
            setup_q[k] <= wdata;
      end
      assign setup[k*DATA_W +: DATA_W] = setup_q[k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         busy_q    <= 1'b0;
         eng_start <= 1'b0;
         eng_abort <= 1'b0;
      end else begin
         eng_start <= go;
         eng_abort <= stop;
         if (end_ev || eng_halted) begin
            run_q  <= 1'b0;
            busy_q <= 1'b0;
         end else if (go) begin
            run_q  <= 1'b1;
            busy_q <= 1'b1;
         end else if (stop) begin
            run_q  <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw_q <= '0;
         ien_q <= '0;
      end else begin
         raw_q <= (raw_q & ~((wr_en && word == W_RAW) ? wdata[1:0] : 2'b00))
                  | {eng_error, eng_done};
         if (wr_en && word == W_IEN) ien_q <= wdata[1:0];
      end
   end

   assign masked = raw_q & ien_q;
   assign irq    = |masked;

   always_comb begin
      rdata = '0;
      case (word)
         W_CTL:   rdata[0]   = run_q;
         W_IEN:   rdata[1:0] = ien_q;
         W_STAT:  rdata[0]   = busy_q;
         W_RAW:   rdata[1:0] = raw_q;
         W_MSK:   rdata[1:0] = masked;
         default: ;
      endcase
      for (int k = 0; k < SETUP_N; k++)
         if (word == setup_word(k)) rdata = setup_q[k];
   end

   // R3: start pulse coincides with a running, busy channel
   a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> (busy_q && run_q));
   // R4: setup words frozen across a busy edge
   a_r4_setup_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> $stable(setup));
   // R5: draining channel keeps busy until the engine halts
   a_r5_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !run_q && !eng_halted && !eng_done && !eng_error) |=> busy_q);
   // R6: end or error event idles the channel
   a_r6_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done || eng_error) |=> (!busy_q && !run_q));
   // R7: done event always leaves the end flag set
   a_r7_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> raw_q[0]);
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
   import dmac_pkg::*;
#(
   parameter  int NUM_CH  = 4,
   parameter  int IRQ_REG = 0,
   localparam int CHW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int AW      = 8 + CHW
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             bus_we,
   input  logic [AW-1:0]                    bus_addr,
   input  logic [DATA_W-1:0]                bus_wdata,
   output logic [DATA_W-1:0]                bus_rdata,
   output logic [NUM_CH-1:0]                eng_start_o,
   output logic [NUM_CH-1:0]                eng_abort_o,
   input  logic [NUM_CH-1:0]                eng_done_i,
   input  logic [NUM_CH-1:0]                eng_error_i,
   input  logic [NUM_CH-1:0]                eng_halted_i,
   output logic [NUM_CH*SETUP_N*DATA_W-1:0] setup_o,
   output logic                             irq_o
);
   localparam int SLICE_W = SETUP_N * DATA_W;

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_nch
      $error("dmac_regfile: NUM_CH out of range");
   end
   if (IRQ_REG != 0 && IRQ_REG != 1) begin : g_bad_irq
      $error("dmac_regfile: IRQ_REG must be 0 or 1");
   end

   logic [CHW-1:0]    sel;
   logic [WORD_W-1:0] word;
   logic              aligned;
   logic [DATA_W-1:0] chan_rd [NUM_CH];
   logic [NUM_CH-1:0] chan_irq;

   assign sel     = bus_addr[AW-1:8];
   assign word    = bus_addr[7:2];
   assign aligned = (bus_addr[1:0] == 2'b00);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dmac_chan u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_en      (bus_we && aligned && (sel == CHW'(c))),
         .word       (word),
         .wdata      (bus_wdata),
         .rdata      (chan_rd[c]),
         .eng_done   (eng_done_i[c]),
         .eng_error  (eng_error_i[c]),
         .eng_halted (eng_halted_i[c]),
         .eng_start  (eng_start_o[c]),
         .eng_abort  (eng_abort_o[c]),
         .setup      (setup_o[c*SLICE_W +: SLICE_W]),
         .irq        (chan_irq[c])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int c = 0; c < NUM_CH; c++)
         if (aligned && sel == CHW'(c)) bus_rdata = chan_rd[c];
   end

   dmac_irq_merge #(.N(NUM_CH), .REG(IRQ_REG)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_in  (chan_irq),
      .irq_out (irq_o)
   );
endmodule

// File: tb/dmac_regfile_test.sv
module dmac_regfile_test;
   localparam int NCH = 4;
   localparam int AW  = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_we = 1'b0;
   logic [AW-1:0]     bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NCH-1:0]    eng_start_o, eng_abort_o;
   logic [NCH-1:0]    eng_done_i = '0, eng_error_i = '0, eng_halted_i = '0;
   logic [NCH*288-1:0] setup_o;
   logic              irq_o;

   int n_checks = 0;
   int n_errors = 0;

   always #10 clk = ~clk;

   dmac_regfile #(.NUM_CH(NCH)) uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_start_o(eng_start_o), .eng_abort_o(eng_abort_o),
      .eng_done_i(eng_done_i), .eng_error_i(eng_error_i),
      .eng_halted_i(eng_halted_i), .setup_o(setup_o), .irq_o(irq_o));

   typedef struct packed {
      logic [9:0]  a;
      logic [31:0] d;
      logic [31:0] e;
   } vec_t;

   localparam vec_t VECS [12] = '{
      '{10'h008, 32'h1111_0008, 32'h1111_0008},
      '{10'h010, 32'h2222_0010, 32'h2222_0010},
      '{10'h014, 32'h3333_0014, 32'h3333_0014},
      '{10'h018, 32'h4444_0018, 32'h4444_0018},
      '{10'h01C, 32'h5555_001C, 32'h5555_001C},
      '{10'h020, 32'h6666_0020, 32'h6666_0020},
      '{10'h124, 32'h7777_0124, 32'h7777_0124},
      '{10'h228, 32'h8888_0228, 32'h8888_0228},
      '{10'h32C, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
      '{10'h140, 32'hFFFF_FFFF, 32'h0000_0000},
      '{10'h248, 32'h0000_0003, 32'h0000_0000},
      '{10'h004, 32'hDEAD_BEEF, 32'h0000_0000}
   };

   task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic pulse(input int kind, input int ch);
      @(negedge clk);
      case (kind)
         0: eng_done_i[ch]   = 1'b1;
         1: eng_error_i[ch]  = 1'b1;
         default: eng_halted_i[ch] = 1'b1;
      endcase
      @(negedge clk);
      eng_done_i = '0; eng_error_i = '0; eng_halted_i = '0;
   endtask

   initial begin
      #3_000_000;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rd(10'h030, v); chk(v, 0, "R1 ctl");
      rd(10'h040, v); chk(v, 0, "R1 status");
      rd(10'h144, v); chk(v, 0, "R1 raw");
      rd(10'h348, v); chk(v, 0, "R1 masked");
      rd(10'h228, v); chk(v, 0, "R1 setup");
      chk({31'b0, irq_o}, 0, "R1 irq");
      chk({24'b0, eng_start_o, eng_abort_o}, 0, "R1 pulses");

      // R2 R9 R11: vector table, writes then readback
      for (int i = 0; i < 12; i++) wr(VECS[i].a, VECS[i].d);
      for (int i = 0; i < 12; i++) begin
         rd(VECS[i].a, v);
         chk(v, VECS[i].e, "R2/R9/R11 table");
      end
      chk(setup_o[0*288 + 0*32 +: 32], 32'h1111_0008, "R2 setup_o c0 k0");
      chk(setup_o[1*288 + 6*32 +: 32], 32'h7777_0124, "R2 setup_o c1 k6");
      chk(setup_o[3*288 + 8*32 +: 32], 32'hFFFF_FFFF, "R2 setup_o c3 k8");
      rd(10'h124, v); chk(v, 32'h7777_0124, "R9 channel window");
      rd(10'h024, v); chk(v, 0, "R9 other channel untouched");

      // R3: start channel 0
      wr(10'h030, 32'h1);
      chk({31'b0, eng_start_o[0]}, 1, "R3 start pulse");
      rd(10'h040, v); chk(v, 1, "R3 busy");
      rd(10'h030, v); chk(v, 1, "R3 run");
      @(negedge clk);
      chk({31'b0, eng_start_o[0]}, 0, "R3 pulse one cycle");

      // R4: setup write while busy
      wr(10'h020, 32'hABCD_0000);
      rd(10'h020, v); chk(v, 32'h6666_0020, "R4 setup frozen");

      // R10: second start while busy
      wr(10'h030, 32'h1);
      chk({31'b0, eng_start_o[0]}, 0, "R10 no restart");

      // R5: stop request and drain
      wr(10'h030, 32'h0);
      chk({31'b0, eng_abort_o[0]}, 1, "R5 abort pulse");
      rd(10'h030, v); chk(v, 0, "R5 run cleared");
      repeat (5) @(negedge clk);
      chk({31'b0, eng_abort_o[0]}, 0, "R5 abort one pulse");
      rd(10'h040, v); chk(v, 1, "R5 busy while draining");
      pulse(2, 0);
      rd(10'h040, v); chk(v, 0, "R5 busy after halt");
      rd(10'h044, v); chk(v, 0, "R5 halt sets no flag");

      // R6 R7 R8 R9: done on channel 1 with end enable
      wr(10'h134, 32'h1);
      wr(10'h130, 32'h1);
      pulse(0, 1);
      rd(10'h140, v); chk(v, 0, "R6 busy cleared");
      rd(10'h130, v); chk(v, 0, "R6 run cleared");
      rd(10'h144, v); chk(v, 1, "R7 end flag");
      rd(10'h148, v); chk(v, 1, "R8 masked end");
      chk({31'b0, irq_o}, 1, "R9 irq set");
      wr(10'h144, 32'h0);
      rd(10'h144, v); chk(v, 1, "R7 write 0 no effect");
      wr(10'h144, 32'h2);
      rd(10'h144, v); chk(v, 1, "R7 other bit clear no effect");
      wr(10'h148, 32'h0);
      rd(10'h148, v); chk(v, 1, "R11 masked write ignored");
      wr(10'h144, 32'h1);
      rd(10'h144, v); chk(v, 0, "R7 w1c");
      chk({31'b0, irq_o}, 0, "R9 irq cleared");

      // R6 R8: error on channel 2 with enables off
      wr(10'h230, 32'h1);
      pulse(1, 2);
      rd(10'h240, v); chk(v, 0, "R6 error clears busy");
      rd(10'h244, v); chk(v, 2, "R7 error flag");
      rd(10'h248, v); chk(v, 0, "R8 masked off");
      chk({31'b0, irq_o}, 0, "R8 irq off when disabled");
      wr(10'h234, 32'h2);
      rd(10'h248, v); chk(v, 2, "R8 masked error");
      chk({31'b0, irq_o}, 1, "R9 irq from channel 2");
      wr(10'h244, 32'h3);
      chk({31'b0, irq_o}, 0, "R9 irq after clear");

      // R7: event and clearing write in the same cycle
      @(negedge clk);
      eng_done_i[3] = 1'b1;
      bus_we = 1'b1; bus_addr = 10'h344; bus_wdata = 32'h1;
      @(negedge clk);
      eng_done_i = '0; bus_we = 1'b0;
      rd(10'h344, v); chk(v, 1, "R7 set wins over clear");
      wr(10'h344, 32'h1);
      rd(10'h344, v); chk(v, 0, "R7 cleared afterwards");

      // R11: misaligned address not decoded
      rd(10'h009, v); chk(v, 0, "R11 misaligned read");

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule